// File: doc/BRIEF.md
# Multi-Line Receive Character Scanner

This block watches a set of receive lines, each offering one character at a time through a valid/data pair, and moves one character into a single holding word that the host reads. When the block is armed and the holding word is empty, it grants the lowest-numbered line that has a character waiting. It cuts the character down to that line's configured length, adds the line number and a data-present bit, and raises the receive flag. When the host has enabled the receive interrupt, the flag also drives the interrupt output.

After a capture, the scan stops. It starts again only after the host reads the holding word, which empties it, or after a line-setup write that carries a non-zero receive rate. Lines that lose arbitration keep offering their character until they receive a ready. Bit-level deserialization, rate generation and any deeper receive buffer are handled elsewhere.

Top module: `rx_line_scanner`

## Requirements
- R1: After reset, the holding word is 0, the receive flag, the interrupt and every line ready are low, and the scan is disarmed: no character is captured until a read or a qualifying setup write arms it.
- R2: The 2-bit length code of a line selects a kept width of 5, 6, 7 or 8 bits for codes 0, 1, 2 and 3. Captured character bits at and above that width read as zero. Every line's code resets to 0.
- R3: A captured word holds the masked character in bits 7:0, the line number in bits 11:8, zeros in bits 14:12 and a 1 in bit 15.
- R4: A capture sets the receive flag on the same clock edge that loads the word. The interrupt output is high exactly when the flag is set and the interrupt enable input is high.
- R5: In a cycle where a capture is possible, only the lowest-numbered line with its valid high gets line ready. At most one line ready is high in any cycle.
- R6: A line whose valid is high but which is not granted sees ready low and keeps its character. That character is captured unchanged when the line later wins.
- R7: While the holding word is full, no line ready is raised and the word does not change. A read pulse empties the word and clears the flag at the next edge, and it arms the scan.
- R8: A setup write stores the length code for the addressed line. It arms the scan only when its 4-bit receive rate field is non-zero. A write with rate 0 changes only the length.
- R9: A capture disarms the scan. No capture happens in the cycle of a read pulse or in the cycle right after a capture, so at most one new scan starts per clock after the word empties.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_valid | input | 16 | Per-line character waiting |
| line_data | input | 128 | Per-line character, line i in bits 8i+7:8i |
| line_ready | output | 16 | Per-line grant; character taken at this edge |
| cfg_wr | input | 1 | Line setup write strobe |
| cfg_line | input | 4 | Line addressed by the setup write |
| cfg_len_code | input | 2 | Length code written (0..3 for 5..8 bits) |
| cfg_rx_rate | input | 4 | Receive rate field; non-zero arms the scan |
| rx_int_en | input | 1 | Receive interrupt enable |
| hold_rd | input | 1 | Host read of the holding word; clears it |
| hold_word | output | 16 | Holding word: character, line tag, data-present bit |
| rx_flag | output | 1 | Receive flag, set by capture, cleared by read |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
On every cycle, the assertions check the following. At most one line is granted, and no grant goes to a line without valid. A full holding word stays unchanged until it is read. A read empties the word and the flag. A capture sets the flag and the data-present bit. Captures never come from a disarmed scan, in a read cycle or back to back. Whether the grant goes to the lowest pending line, whether the character is masked to the right width per line, whether a losing line's character survives and whether setup writes arm or leave the scan idle all depend on which lines were pending and what was configured, so only the bench's reference model can show them.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

   localparam int RXS_LEN_CODE_W = 2;
   localparam int RXS_MIN_LEN    = 5;

   typedef enum logic {
      ARB_SCAN = 1'b0,
      ARB_TWOS = 1'b1
   } rxs_arb_e;

   function automatic int rxs_kept_width(input logic [RXS_LEN_CODE_W-1:0] code);
      return RXS_MIN_LEN + int'(code);
   endfunction

endpackage

// File: rtl/rxs_len_table.sv
module rxs_len_table
   import rxs_pkg::*;
#(
   parameter int NUM_LINES  = 16,
   parameter int LINE_IDX_W = 4,
   parameter int RATE_W     = 4
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  cfg_wr,
   input  logic [LINE_IDX_W-1:0]                 cfg_line,
   input  logic [RXS_LEN_CODE_W-1:0]             cfg_len_code,
   input  logic [RATE_W-1:0]                     cfg_rx_rate,
   output logic [NUM_LINES*RXS_LEN_CODE_W-1:0]   len_flat,
   output logic                                  restart
);

   logic [RXS_LEN_CODE_W-1:0] len_q [NUM_LINES];

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            len_q[i] <= '0;
         end else if (cfg_wr && (cfg_line == LINE_IDX_W'(i))) begin
            len_q[i] <= cfg_len_code;
         end
      end
      assign len_flat[i*RXS_LEN_CODE_W +: RXS_LEN_CODE_W] = len_q[i];
   end

   assign restart = cfg_wr && (cfg_rx_rate != '0);

endmodule

// File: rtl/rxs_prio_arb.sv
module rxs_prio_arb
   import rxs_pkg::*;
#(
   parameter int       NUM_LINES  = 16,
   parameter int       LINE_IDX_W = 4,
   parameter rxs_arb_e IMPL       = ARB_TWOS
) (
   input  logic [NUM_LINES-1:0]  req,
   output logic [NUM_LINES-1:0]  grant,
   output logic [LINE_IDX_W-1:0] grant_idx,
   output logic                  any_req
);

   if (IMPL == ARB_TWOS) begin : g_twos
      assign grant = req & (~req + NUM_LINES'(1));
   end else begin : g_scan
      always_comb begin
         grant = '0;
         for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (req[i]) begin
               grant    = '0;
               grant[i] = 1'b1;
            end
         end
      end
   end

   always_comb begin
      grant_idx = '0;
      for (int i = 0; i < NUM_LINES; i++) begin
         if (grant[i]) grant_idx = grant_idx | LINE_IDX_W'(i);
      end
   end

   assign any_req = |req;

endmodule

// File: rtl/rxs_char_mask.sv
module rxs_char_mask
   import rxs_pkg::*;
#(
   parameter int NUM_LINES  = 16,
   parameter int CHAR_W     = 8,
   parameter int LINE_IDX_W = 4
) (
   input  logic [NUM_LINES*CHAR_W-1:0]          data_flat,
   input  logic [NUM_LINES*RXS_LEN_CODE_W-1:0]  len_flat,
   input  logic [LINE_IDX_W-1:0]                sel,
   output logic [CHAR_W-1:0]                    char_out
);

   logic [CHAR_W-1:0]         raw;
   logic [RXS_LEN_CODE_W-1:0] code;
   logic [CHAR_W-1:0]         keep;

   always_comb begin
      raw  = '0;
      code = '0;
      for (int i = 0; i < NUM_LINES; i++) begin
         if (sel == LINE_IDX_W'(i)) begin
            raw  = data_flat[i*CHAR_W +: CHAR_W];
            code = len_flat[i*RXS_LEN_CODE_W +: RXS_LEN_CODE_W];
         end
      end
      for (int b = 0; b < CHAR_W; b++) begin
         keep[b] = (b < rxs_kept_width(code));
      end
      char_out = raw & keep;
   end

endmodule

// File: rtl/rxs_hold_reg.sv
module rxs_hold_reg #(
   parameter int WORD_W    = 16,
   parameter int VALID_BIT = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic [WORD_W-1:0] cap_word,
   input  logic              hold_rd,
   input  logic              restart,
   output logic              armed,
   output logic              full,
   output logic [WORD_W-1:0] hold_word,
   output logic              rx_flag
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed     <= 1'b0;
         hold_word <= '0;
         rx_flag   <= 1'b0;
      end else begin
         if (hold_rd) begin
            hold_word <= '0;
            rx_flag   <= 1'b0;
         end else if (capture) begin
            hold_word <= cap_word;
            rx_flag   <= 1'b1;
         end
         armed <= (armed && !capture) || hold_rd || restart;
      end
   end

   assign full = hold_word[VALID_BIT];

   // R7: a full word holds until read
   assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !hold_rd) |=> $stable(hold_word));

   // R7: a read empties word and flag
   assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      hold_rd |=> (hold_word == '0 && !rx_flag));

   // R4: a capture sets flag and data-present bit
   assert_capture_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
      capture |=> (rx_flag && hold_word[VALID_BIT]));

   // R1: nothing is taken while disarmed
   assert_disarmed_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      capture |-> armed);

   // R9: no capture in a read cycle nor back to back
   assert_no_capture_on_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
      hold_rd |-> !capture);
   assert_single_scan_R9: assert property (@(posedge clk) disable iff (!rst_n)
      capture |=> !capture);

   // R8: a qualifying setup write arms the scan
   assert_restart_arms_R8: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> armed);

endmodule

// File: rtl/rx_line_scanner.sv
module rx_line_scanner
   import rxs_pkg::*;
#(
   parameter int       NUM_LINES  = 16,
   parameter int       CHAR_W     = 8,
   parameter int       WORD_W     = 16,
   parameter int       TAG_LSB    = 8,
   parameter int       VALID_BIT  = 15,
   parameter int       RATE_W     = 4,
   parameter rxs_arb_e ARB_IMPL   = ARB_TWOS,
   localparam int      LINE_IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_LINES-1:0]          line_valid,
   input  logic [NUM_LINES*CHAR_W-1:0]   line_data,
   output logic [NUM_LINES-1:0]          line_ready,
   input  logic                          cfg_wr,
   input  logic [LINE_IDX_W-1:0]         cfg_line,
   input  logic [RXS_LEN_CODE_W-1:0]     cfg_len_code,
   input  logic [RATE_W-1:0]             cfg_rx_rate,
   input  logic                          rx_int_en,
   input  logic                          hold_rd,
   output logic [WORD_W-1:0]             hold_word,
   output logic                          rx_flag,
   output logic                          rx_irq
);

   if (CHAR_W < RXS_MIN_LEN + (1 << RXS_LEN_CODE_W) - 1) begin : g_bad_char
      $error("CHAR_W too narrow for the largest length code");
   end
   if (TAG_LSB < CHAR_W || TAG_LSB + LINE_IDX_W > VALID_BIT) begin : g_bad_tag
      $error("line tag overlaps character or data-present bit");
   end
   if (VALID_BIT >= WORD_W) begin : g_bad_valid
      $error("data-present bit outside the holding word");
   end
   if (NUM_LINES < 1) begin : g_bad_lines
      $error("NUM_LINES must be at least 1");
   end

   logic [NUM_LINES*RXS_LEN_CODE_W-1:0] len_flat;
   logic                                restart;
   logic [NUM_LINES-1:0]                grant;
   logic [LINE_IDX_W-1:0]               grant_idx;
   logic                                any_req;
   logic [CHAR_W-1:0]                   masked_char;
   logic                                armed;
   logic                                full;
   logic                                scan_ok;
   logic                                capture;
   logic [WORD_W-1:0]                   cap_word;

   rxs_len_table #(
      .NUM_LINES  (NUM_LINES),
      .LINE_IDX_W (LINE_IDX_W),
      .RATE_W     (RATE_W)
   ) u_len (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_wr       (cfg_wr),
      .cfg_line     (cfg_line),
      .cfg_len_code (cfg_len_code),
      .cfg_rx_rate  (cfg_rx_rate),
      .len_flat     (len_flat),
      .restart      (restart)
   );

   rxs_prio_arb #(
      .NUM_LINES  (NUM_LINES),
      .LINE_IDX_W (LINE_IDX_W),
      .IMPL       (ARB_IMPL)
   ) u_arb (
      .req       (line_valid),
      .grant     (grant),
      .grant_idx (grant_idx),
      .any_req   (any_req)
   );

   rxs_char_mask #(
      .NUM_LINES  (NUM_LINES),
      .CHAR_W     (CHAR_W),
      .LINE_IDX_W (LINE_IDX_W)
   ) u_mask (
      .data_flat (line_data),
      .len_flat  (len_flat),
      .sel       (grant_idx),
      .char_out  (masked_char)
   );

   assign scan_ok    = armed && !full && !hold_rd;
   assign capture    = scan_ok && any_req;
   assign line_ready = scan_ok ? grant : '0;

   always_comb begin
      cap_word                           = '0;
      cap_word[CHAR_W-1:0]               = masked_char;
      cap_word[TAG_LSB +: LINE_IDX_W]    = grant_idx;
      cap_word[VALID_BIT]                = 1'b1;
   end

   rxs_hold_reg #(
      .WORD_W    (WORD_W),
      .VALID_BIT (VALID_BIT)
   ) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .capture   (capture),
      .cap_word  (cap_word),
      .hold_rd   (hold_rd),
      .restart   (restart),
      .armed     (armed),
      .full      (full),
      .hold_word (hold_word),
      .rx_flag   (rx_flag)
   );

   assign rx_irq = rx_flag && rx_int_en;

   // R5: never more than one grant
   assert_ready_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(line_ready));

   // R6: a grant only goes to a line offering a character
   assert_ready_needs_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (line_ready & ~line_valid) == '0);

   // R7: no grant while the word is full
   assert_no_ready_when_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
      hold_word[VALID_BIT] |-> (line_ready == '0));

   // R4: interrupt only with the flag raised
   assert_irq_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rx_irq |-> rx_flag);

endmodule

// File: tb/rx_line_scanner_tb_top.sv
module rx_line_scanner_tb_top;

   localparam int NL = 16;
   localparam int CW = 8;

   logic            clk = 1'b0;
   logic            rst_n;
   logic [NL-1:0]   line_valid;
   logic [NL*CW-1:0] line_data;
   logic [NL-1:0]   line_ready;
   logic            cfg_wr;
   logic [3:0]      cfg_line;
   logic [1:0]      cfg_len_code;
   logic [3:0]      cfg_rx_rate;
   logic            rx_int_en;
   logic            hold_rd;
   logic [15:0]     hold_word;
   logic            rx_flag;
   logic            rx_irq;

   int checks   = 0;
   int failures = 0;
   bit done     = 1'b0;

   always #5 clk = ~clk;

   rx_line_scanner dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .line_valid   (line_valid),
      .line_data    (line_data),
      .line_ready   (line_ready),
      .cfg_wr       (cfg_wr),
      .cfg_line     (cfg_line),
      .cfg_len_code (cfg_len_code),
      .cfg_rx_rate  (cfg_rx_rate),
      .rx_int_en    (rx_int_en),
      .hold_rd      (hold_rd),
      .hold_word    (hold_word),
      .rx_flag      (rx_flag),
      .rx_irq       (rx_irq)
   );

   // bench-side line sources and reference model
   logic [NL-1:0] pend_v;
   logic [7:0]    pend_d [NL];
   logic [1:0]    m_len  [NL];
   logic          m_armed;
   logic          m_full;
   logic [15:0]   m_word;

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] keep_bits(input logic [7:0] d, input logic [1:0] code);
      logic [7:0] m;
      for (int b = 0; b < 8; b++) m[b] = (b < 5 + int'(code));
      return d & m;
   endfunction

   function automatic logic [15:0] mk_word(input int ln, input logic [7:0] d,
                                           input logic [1:0] code);
      return {1'b1, 3'b000, 4'(ln), keep_bits(d, code)};
   endfunction

   function automatic logic [NL-1:0] lowest(input logic [NL-1:0] v);
      for (int i = 0; i < NL; i++) if (v[i]) return NL'(1) << i;
      return '0;
   endfunction

   function automatic int lowest_idx(input logic [NL-1:0] v);
      for (int i = 0; i < NL; i++) if (v[i]) return i;
      return 0;
   endfunction

   // Called at a negedge; returns at the following negedge.
   task automatic step(input logic rd, input logic cw, input logic [3:0] cl,
                       input logic [1:0] clen, input logic [3:0] crate, input logic en);
      logic [NL-1:0] exp_rdy;
      bit cap;
      int gi;
      line_valid = pend_v;
      for (int i = 0; i < NL; i++) line_data[i*CW +: CW] = pend_d[i];
      hold_rd = rd; cfg_wr = cw; cfg_line = cl; cfg_len_code = clen;
      cfg_rx_rate = crate; rx_int_en = en;
      #1;
      cap = m_armed && !m_full && !rd && (pend_v != '0);
      exp_rdy = cap ? lowest(pend_v) : '0;
      check(line_ready == exp_rdy, "R5 ready", 32'(line_ready), 32'(exp_rdy));
      @(posedge clk);
      if (cap) begin
         gi = lowest_idx(pend_v);
         m_word = mk_word(gi, pend_d[gi], m_len[gi]);
         m_full = 1'b1;
         pend_v[gi] = 1'b0;
      end
      if (rd) begin
         m_full = 1'b0;
         m_word = '0;
      end
      if (cw) m_len[cl] = clen;
      m_armed = (m_armed && !cap) || rd || (cw && crate != 0);
      @(negedge clk);
      hold_rd = 1'b0; cfg_wr = 1'b0;
      check(hold_word == m_word, "R3 word", 32'(hold_word), 32'(m_word));
      check(rx_flag == m_full, "R4 flag", 32'(rx_flag), 32'(m_full));
      check(rx_irq == (m_full && en), "R4 irq", 32'(rx_irq), 32'(m_full && en));
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) step(1'b0, 1'b0, 4'd0, 2'd0, 4'd0, 1'b1);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : main
      int seed;
      logic [7:0] d;
      seed = $urandom(32'd4711);
      rst_n = 1'b0; line_valid = '0; line_data = '0; hold_rd = 1'b0; cfg_wr = 1'b0;
      cfg_line = '0; cfg_len_code = '0; cfg_rx_rate = '0; rx_int_en = 1'b1;
      pend_v = '0;
      for (int i = 0; i < NL; i++) begin pend_d[i] = '0; m_len[i] = '0; end
      m_armed = 1'b0; m_full = 1'b0; m_word = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      check(hold_word == 16'h0, "R1 word", 32'(hold_word), 0);
      check(rx_flag == 1'b0 && rx_irq == 1'b0, "R1 flag", 32'({rx_flag, rx_irq}), 0);
      check(line_ready == '0, "R1 ready", 32'(line_ready), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: disarmed scan ignores a waiting line
      pend_v[2] = 1'b1; pend_d[2] = 8'hFF;
      idle(3);
      check(hold_word == 16'h0 && pend_v[2], "R1 disarmed", 32'(hold_word), 0);

      // R8: setup write with rate 0 stores length only
      step(1'b0, 1'b1, 4'd2, 2'd1, 4'd0, 1'b1);
      idle(2);
      check(hold_word == 16'h0, "R8 rate0 no arm", 32'(hold_word), 0);

      // R8 / R2: non-zero rate arms; line 2 captured with 6-bit length
      step(1'b0, 1'b1, 4'd7, 2'd3, 4'd5, 1'b1);
      idle(1);
      check(hold_word == 16'h823F, "R2 six-bit mask", 32'(hold_word), 32'h823F);

      // R7 / R5 / R6: word held while full; lines 9 and 3 wait
      pend_v[9] = 1'b1; pend_d[9] = 8'h5A;
      pend_v[3] = 1'b1; pend_d[3] = 8'hC3;
      idle(3);
      check(hold_word == 16'h823F, "R7 held", 32'(hold_word), 32'h823F);
      line_valid = pend_v;
      #1;
      check(line_ready == '0, "R7 no ready when full", 32'(line_ready), 0);
      // R9: read cycle grants nothing
      step(1'b1, 1'b0, 4'd0, 2'd0, 4'd0, 1'b1);
      check(hold_word == 16'h0 && !rx_flag, "R7 read clears", 32'(hold_word), 0);
      idle(1);
      check(hold_word == 16'h8303, "R5 lowest first", 32'(hold_word), 32'h8303);
      check(pend_v[9] == 1'b1, "R6 loser kept", 32'(pend_v[9]), 1);
      step(1'b1, 1'b0, 4'd0, 2'd0, 4'd0, 1'b1);
      idle(1);
      check(hold_word == 16'h891A, "R6 loser delivered", 32'(hold_word), 32'h891A);

      // R4: interrupt follows enable
      step(1'b0, 1'b0, 4'd0, 2'd0, 4'd0, 1'b0);
      check(rx_flag && !rx_irq, "R4 irq masked", 32'(rx_irq), 0);
      step(1'b1, 1'b0, 4'd0, 2'd0, 4'd0, 1'b1);

      // R2: every length code on line 15
      for (int c = 0; c < 4; c++) begin
         step(1'b0, 1'b1, 4'd15, 2'(c), 4'd0, 1'b1);
         pend_v[15] = 1'b1; pend_d[15] = 8'hFF;
         idle(1);
         check(hold_word == mk_word(15, 8'hFF, 2'(c)), "R2 code", 32'(hold_word),
               32'(mk_word(15, 8'hFF, 2'(c))));
         step(1'b1, 1'b0, 4'd0, 2'd0, 4'd0, 1'b1);
      end

      // R9: capture disarms; two reads-free cycles take only one line
      pend_v[4] = 1'b1; pend_d[4] = 8'h11;
      pend_v[6] = 1'b1; pend_d[6] = 8'h22;
      idle(3);
      check(pend_v[6] == 1'b1, "R9 one per empty", 32'(pend_v[6]), 1);
      step(1'b1, 1'b0, 4'd0, 2'd0, 4'd0, 1'b1);

      // constrained random traffic
      for (int n = 0; n < 3000; n++) begin
         logic rd, cw, en;
         logic [3:0] cl, cr;
         logic [1:0] clen;
         for (int i = 0; i < NL; i++) begin
            if (!pend_v[i] && ($urandom % 8) == 0) begin
               d = 8'($urandom);
               pend_v[i] = 1'b1; pend_d[i] = d;
            end
         end
         rd   = (m_full && ($urandom % 4) == 0) || (($urandom % 40) == 0);
         cw   = (($urandom % 16) == 0);
         cl   = 4'($urandom);
         clen = 2'($urandom);
         cr   = (($urandom % 2) == 0) ? 4'd0 : 4'($urandom);
         en   = (($urandom % 4) != 0);
         step(rd, cw, cl, clen, cr, en);
      end

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule